// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous pipelined static RAM. Reads and writes can follow each other on every clock with no idle slot on the shared data bus. Each word has 36 bits: four byte lanes of 8 data bits, and one parity bit per lane. Address, control and byte-write inputs are registered on the rising clock edge. The data that belongs to a write is sampled two enabled edges after its address. Read data is launched from an output register so that it occupies the same bus slot. Because read data and write data use the same slot, a controller can interleave the two freely without turnaround gaps.

An advance/load strobe chooses between two actions. It either loads a new external address or continues a four-beat burst from the last loaded address. The burst steps in linear or interleaved order. The three chip enables must all be active for the device to be selected. The clock enable freezes the whole pipeline. The output enable gates the drivers without waiting for a clock. The bidirectional bus is split into an input bus, an output bus and an output-enable port. The word depth is set by the address-width parameter; the default is kept small, and a 17-bit setting gives the full 128K-word array.

Top module: `zbt_sram`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `d_oe` is 0 whatever the state of `oe_n`, and no access is pending.
- R2: A load (`adv_ld`=0) selects the device only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Any other combination is a deselect, and after the next enabled edge `d_oe` is 0.
- R3: A read load (`wr_n`=1) captured at enabled edge k places the addressed word on `d_out` after enabled edge k+1. `d_oe` is 1 (with `oe_n`=0) until the next enabled edge, so the word can be sampled at edge k+2.
- R4: A write load (`wr_n`=0) captured at enabled edge k writes `d_in` as sampled at enabled edge k+2. Lane n holds data bits `d_in[8n+7:8n]` and parity bit `d_in[32+n]`. It is written only when `bw_n[n]`=0, and the other lanes keep their contents.
- R5: In the cycle whose closing edge samples a write's data, `d_oe` is 0 even when `oe_n` is 0.
- R6: Reads and writes may alternate on every enabled edge. A read returns the newest data, including lanes of a write whose data is sampled on the same edge at which the read's output register loads.
- R7: An advance (`adv_ld`=1) repeats the kind of access last loaded: read, write or deselect. On an advance, `sel1_n`, `sel2`, `sel3_n` and `wr_n` are ignored. `bw_n` is sampled on every write beat.
- R8: Burst beat j (j = 0,1,2,3, wrapping after 3) from start address S keeps the upper address bits of S. Its two low bits are S[1:0]+j mod 4 when `burst_lin` was 1 at the load, and S[1:0] XOR j when it was 0. The order latched at the load holds for the whole burst.
- R9: A clock edge with `clk_en_n`=1 is ignored. All pipeline, burst and output state holds, so `d_out` and `d_oe` keep their values and pending write data is taken at the next enabled edge instead.
- R10: `oe_n`=1 forces `d_oe` to 0 at once, without a clock edge, and `d_oe` returns when `oe_n` goes low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Clock enable, active low; high ignores the edge |
| sel1_n | input | 1 | Chip enable 1, active low |
| sel2 | input | 1 | Chip enable 2, active high |
| sel3_n | input | 1 | Chip enable 3, active low |
| wr_n | input | 1 | Write enable on a load, active low |
| bw_n | input | LANES | Byte-lane write selects, active low |
| adv_ld | input | 1 | 0 loads an external address, 1 advances the burst |
| burst_lin | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| d_in | input | LANES*(LANE_D+1) | Write data, parity in the top LANES bits |
| d_out | output | LANES*(LANE_D+1) | Read data from the output register |
| d_oe | output | 1 | High when the block drives the data bus |

## Verification
The assertions check properties on every cycle. They check that the bus is never driven while a write's data phase is in stage two. They check that a stalled edge changes neither the output register, the drive flag nor the command stages. They check that an advance keeps the access kind, and that a read load or a deselect load sets or clears the drive flag one enabled edge later. Data values cannot be checked this way. Lane merging, same-edge forwarding between a committing write and a loading read, both burst orders with wrap-around, the order latched at load, and write data held across stalled edges are shown only by the bench's scenarios against its own memory model. The asynchronous effect of the output enable is also shown only by the bench.

// File: rtl/zbt_pkg.sv
// Shared types for the zero-turnaround SRAM.
// Assumes a fixed four-beat burst on the two low address bits.
package zbt_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10
    } op_e;

    localparam int BEAT_W = 2;

    // Low address bits of a burst beat for either order.
    function automatic logic [BEAT_W-1:0] beat_lsb(input logic [BEAT_W-1:0] start,
                                                   input logic [BEAT_W-1:0] step,
                                                   input logic linear);
        return linear ? (start + step) : (start ^ step);
    endfunction
endpackage

// File: rtl/zbt_burst_addr.sv
// Burst address generator. A load passes the external address through and
// records it as the burst start. An advance yields the next beat address in
// the order latched at the load.
// Assumes ADDR_W > BEAT_W; the step only happens on enabled edges.
module zbt_burst_addr
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              load,
    input  logic              lin_mode,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] nxt_cnt;
    logic              lin_q;

    assign nxt_cnt = cnt_q + 1'b1;

    // Pick the address this edge's command will use.
    always_comb begin
        if (load) begin
            cur_addr = ext_addr;
        end else begin
            cur_addr = {base_q[ADDR_W-1:BEAT_W], beat_lsb(base_q[BEAT_W-1:0], nxt_cnt, lin_q)};
        end
    end

    // Track the burst start, order and beat count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            lin_q  <= 1'b0;
        end else if (step_en) begin
            if (load) begin
                base_q <= ext_addr;
                cnt_q  <= '0;
                lin_q  <= lin_mode;
            end else begin
                cnt_q  <= nxt_cnt;
            end
        end
    end
endmodule

// File: rtl/zbt_cmd_pipe.sv
// Command decode and two-stage command pipeline. Stage A holds the command
// captured at the last enabled edge. Stage B holds the command whose data
// slot closes at the next enabled edge. An advance repeats the last loaded kind.
// Assumes the select and write-enable inputs are already decoded to levels.
module zbt_cmd_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              load,
    input  logic              selected,
    input  logic              wr_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] cur_addr,
    output op_e               a_op,
    output logic [ADDR_W-1:0] a_addr,
    output op_e               b_op,
    output logic [ADDR_W-1:0] b_addr,
    output logic [LANES-1:0]  b_bw_n
);
    op_e              kind_q;
    op_e              nxt_op;
    logic [LANES-1:0] a_bw_n;

    // Decode the command kind for this edge.
    always_comb begin
        if (load) begin
            if (selected) begin
                nxt_op = wr_n ? OP_READ : OP_WRITE;
            end else begin
                nxt_op = OP_IDLE;
            end
        end else begin
            nxt_op = kind_q;
        end
    end

    // Shift commands through stages A and B on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= OP_IDLE;
            a_op   <= OP_IDLE;
            a_addr <= '0;
            a_bw_n <= '1;
            b_op   <= OP_IDLE;
            b_addr <= '0;
            b_bw_n <= '1;
        end else if (step_en) begin
            kind_q <= nxt_op;
            a_op   <= nxt_op;
            a_addr <= cur_addr;
            a_bw_n <= bw_n;
            b_op   <= a_op;
            b_addr <= a_addr;
            b_bw_n <= a_bw_n;
        end
    end
endmodule

// File: rtl/zbt_array.sv
// Byte-lane storage with the output register. A write in stage B commits
// its lanes from the input bus. A read in stage A loads the output register,
// and any lane committed on the same edge is forwarded from the input bus.
// Assumes lane n is data bits [n*LANE_D +: LANE_D] plus bit LANES*LANE_D+n.
module zbt_array
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_D = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          step_en,
    input  op_e                           a_op,
    input  logic [ADDR_W-1:0]             a_addr,
    input  op_e                           b_op,
    input  logic [ADDR_W-1:0]             b_addr,
    input  logic [LANES-1:0]              b_bw_n,
    input  logic [LANES*(LANE_D+1)-1:0]   wr_data,
    output logic [LANES*(LANE_D+1)-1:0]   rd_q,
    output logic                          drv_q
);
    localparam int LANE_W = LANE_D + 1;
    localparam int WORD_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAR_LO = LANES * LANE_D;

    logic [WORD_W-1:0] rd_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] in_lane;
        logic [LANE_W-1:0] out_lane;
        logic              commit;

        assign in_lane = {wr_data[PAR_LO+g], wr_data[g*LANE_D +: LANE_D]};
        assign commit  = rst_n && step_en && (b_op == OP_WRITE) && !b_bw_n[g];

        // Forward a same-edge commit to the address being read.
        always_comb begin
            if ((b_op == OP_WRITE) && !b_bw_n[g] && (b_addr == a_addr)) begin
                out_lane = in_lane;
            end else begin
                out_lane = store[a_addr];
            end
        end

        assign rd_word[g*LANE_D +: LANE_D] = out_lane[LANE_D-1:0];
        assign rd_word[PAR_LO+g]           = out_lane[LANE_D];

        // Commit this lane of a stage-B write.
        always_ff @(posedge clk) begin
            if (commit) begin
                store[b_addr] <= in_lane;
            end
        end
    end

    // Load the output register and the drive flag for the next bus slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            drv_q <= 1'b0;
        end else if (step_en) begin
            drv_q <= (a_op == OP_READ);
            if (a_op == OP_READ) begin
                rd_q <= rd_word;
            end
        end
    end
endmodule

// File: rtl/zbt_sram.sv
// Top of the zero-turnaround pipelined SRAM. Decodes the pins, runs the
// burst address generator and the command pipeline, and gates the output
// drivers asynchronously with the output enable.
// Assumes the bidirectional bus is resolved outside from d_out and d_oe.
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_D = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clk_en_n,
    input  logic                        sel1_n,
    input  logic                        sel2,
    input  logic                        sel3_n,
    input  logic                        wr_n,
    input  logic [LANES-1:0]            bw_n,
    input  logic                        adv_ld,
    input  logic                        burst_lin,
    input  logic                        oe_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [LANES*(LANE_D+1)-1:0] d_in,
    output logic [LANES*(LANE_D+1)-1:0] d_out,
    output logic                        d_oe
);
    localparam int WORD_W = LANES * (LANE_D + 1);

    logic              step_en;
    logic              load;
    logic              selected;
    logic [ADDR_W-1:0] cur_addr;
    op_e               a_op;
    op_e               b_op;
    logic [ADDR_W-1:0] a_addr;
    logic [ADDR_W-1:0] b_addr;
    logic [LANES-1:0]  b_bw_n;
    logic              drv;
    logic [WORD_W-1:0] rd_q;

    assign step_en  = !clk_en_n;
    assign load     = !adv_ld;
    assign selected = !sel1_n && sel2 && !sel3_n;

    zbt_burst_addr #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .load     (load),
        .lin_mode (burst_lin),
        .ext_addr (addr),
        .cur_addr (cur_addr)
    );

    zbt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .load     (load),
        .selected (selected),
        .wr_n     (wr_n),
        .bw_n     (bw_n),
        .cur_addr (cur_addr),
        .a_op     (a_op),
        .a_addr   (a_addr),
        .b_op     (b_op),
        .b_addr   (b_addr),
        .b_bw_n   (b_bw_n)
    );

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_D(LANE_D)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .a_op    (a_op),
        .a_addr  (a_addr),
        .b_op    (b_op),
        .b_addr  (b_addr),
        .b_bw_n  (b_bw_n),
        .wr_data (d_in),
        .rd_q    (rd_q),
        .drv_q   (drv)
    );

    assign d_out = rd_q;
    assign d_oe  = drv && !oe_n;
endmodule

// File: rtl/zbt_sram_chk.sv
// Property checker for zbt_sram, attached by bind. Observes pins and the
// command stages and drive flag that separate submodules produce.
module zbt_sram_chk
    import zbt_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              adv_ld,
    input logic              sel1_n,
    input logic              sel2,
    input logic              sel3_n,
    input logic              wr_n,
    input logic [WORD_W-1:0] d_out,
    input logic              d_oe,
    input op_e               a_op,
    input op_e               b_op,
    input logic              drv
);
    logic sel_all;
    assign sel_all = !sel1_n && sel2 && !sel3_n;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!d_oe && !drv));

    p_desel_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld && !sel_all) ##1 !clk_en_n |=> !drv);

    p_read_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld && sel_all && wr_n) ##1 !clk_en_n |=> drv);

    p_wdata_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_op == OP_WRITE) |-> !d_oe);

    p_burst_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld) |=> (a_op == $past(a_op)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(d_out) && $stable(drv) && $stable(a_op) && $stable(b_op)));
endmodule

bind zbt_sram zbt_sram_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .adv_ld   (adv_ld),
    .sel1_n   (sel1_n),
    .sel2     (sel2),
    .sel3_n   (sel3_n),
    .wr_n     (wr_n),
    .d_out    (d_out),
    .d_oe     (d_oe),
    .a_op     (a_op),
    .b_op     (b_op),
    .drv      (drv)
);

// File: tb/zbt_sram_test.sv
// Scoreboard bench: the driver task models each edge and queues the expected
// bus state; the monitor pops one item per clock and compares.
module zbt_sram_test;
    localparam int AW = 10;
    localparam int W  = 36;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        logic         exp_oe;
        logic [W-1:0] exp_q;
        string        req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_en_n = 1'b0;
    logic         sel1_n = 1'b1;
    logic         sel2 = 1'b0;
    logic         sel3_n = 1'b1;
    logic         wr_n = 1'b1;
    logic [3:0]   bw_n = 4'hF;
    logic         adv_ld = 1'b0;
    logic         burst_lin = 1'b1;
    logic         oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0] d_in = '0;
    logic [W-1:0] d_out;
    logic         d_oe;

    int checks = 0;
    int errors = 0;
    item_t sb[$];

    // bench reference model
    logic [W-1:0]  mem_m [DEPTH];
    int            ma_op = 0, mb_op = 0, kind = 0;
    logic [AW-1:0] ma_addr = '0, mb_addr = '0, base = '0;
    logic [3:0]    ma_bw = 4'hF, mb_bw = 4'hF;
    logic [1:0]    cnt = '0;
    logic          lin_m = 1'b0;
    logic          m_drv = 1'b0;
    logic [W-1:0]  m_q = '0;
    int            wctr = 1;

    zbt_sram #(.ADDR_W(AW), .LANES(4), .LANE_D(8)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
        .sel3_n(sel3_n), .wr_n(wr_n), .bw_n(bw_n), .adv_ld(adv_ld), .burst_lin(burst_lin),
        .oe_n(oe_n), .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
    );

    always #10 clk = ~clk;

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // One clock: drive pins, model the edge, queue the expected result.
    task automatic cyc(input logic en, input logic ld, input logic [2:0] pins, input logic wrn,
                       input logic [3:0] bwn, input int adr, input logic lin, input string req);
        logic [W-1:0] wd;
        logic [1:0]   lo;
        item_t        it;
        clk_en_n = !en;
        adv_ld = !ld;
        {sel1_n, sel2, sel3_n} = pins;
        wr_n = wrn;
        bw_n = bwn;
        addr = AW'(adr);
        burst_lin = lin;
        wd = {4'(wctr), 32'(wctr) * 32'h9E37_79B1};
        d_in = (mb_op == 2) ? wd : 36'hA_5A5A_5A5A;
        if (en) begin
            if (mb_op == 2) begin
                for (int n = 0; n < 4; n++) begin
                    if (!mb_bw[n]) begin
                        mem_m[mb_addr][8*n +: 8] = wd[8*n +: 8];
                        mem_m[mb_addr][32+n]     = wd[32+n];
                    end
                end
                wctr++;
            end
            if (ma_op == 1) begin
                m_q = mem_m[ma_addr];
                m_drv = 1'b1;
            end else begin
                m_drv = 1'b0;
            end
            mb_op = ma_op; mb_addr = ma_addr; mb_bw = ma_bw;
            if (ld) begin
                base = AW'(adr); cnt = 2'd0; lin_m = lin;
                kind = (pins == 3'b010) ? (wrn ? 1 : 2) : 0;
                ma_addr = AW'(adr);
            end else begin
                cnt = cnt + 2'd1;
                lo = lin_m ? (base[1:0] + cnt) : (base[1:0] ^ cnt);
                ma_addr = {base[AW-1:2], lo};
            end
            ma_op = kind;
            ma_bw = bwn;
        end
        it.exp_oe = m_drv && !oe_n;
        it.exp_q = m_q;
        it.req = req;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic rd(input int a, input string req);
        cyc(1'b1, 1'b1, 3'b010, 1'b1, 4'hF, a, 1'b1, req);
    endtask
    task automatic wr(input int a, input logic [3:0] bw, input string req);
        cyc(1'b1, 1'b1, 3'b010, 1'b0, bw, a, 1'b1, req);
    endtask
    task automatic idle(input string req);
        cyc(1'b1, 1'b1, 3'b110, 1'b1, 4'hF, 0, 1'b1, req);
    endtask
    task automatic adv(input logic wrn, input logic [3:0] bw, input logic lin, input string req);
        cyc(1'b1, 1'b0, 3'b101, wrn, bw, 0, lin, req);
    endtask

    task automatic direct(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: d_oe=%b expected %b", req, act, exp);
        end
    endtask

    // Monitor: pop one expected item per clock, sampled after the edge.
    always @(posedge clk) begin
        item_t it;
        #5;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (d_oe !== it.exp_oe || (it.exp_oe && d_out !== it.exp_q)) begin
                errors++;
                $display("FAIL %s: d_oe=%b d_out=%h expected d_oe=%b d_out=%h",
                         it.req, d_oe, d_out, it.exp_oe, it.exp_q);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
        repeat (3) @(negedge clk);
        direct(d_oe, 1'b0, "R1 reset");
        oe_n = 1'b1;
        #1 direct(d_oe, 1'b0, "R1 reset oe high");
        oe_n = 1'b0;
        rst_n = 1'b1;
        idle("R1"); idle("R1"); idle("R1");

        // R4: fill 0..31 with full-word writes back to back
        for (int a = 0; a < 32; a++) wr(a, 4'h0, "R4");
        idle("R4"); idle("R4");
        // R3: read them back to back
        for (int a = 0; a < 32; a++) rd(a, "R3");
        idle("R3"); idle("R3");

        // R4 partial lanes, then read back
        wr(3, 4'b1010, "R4"); wr(12, 4'b0101, "R4"); wr(20, 4'b0111, "R4");
        idle("R4"); idle("R4");
        rd(3, "R4"); rd(12, "R4"); rd(20, "R4"); idle("R4"); idle("R4");

        // R5: alternate read and write, bus quiet in write slots
        rd(1, "R5"); wr(2, 4'h0, "R5"); rd(2, "R5"); wr(1, 4'h0, "R5");
        rd(1, "R5"); idle("R5"); idle("R5");

        // R6: write then read same address next cycle (same-edge forward)
        wr(7, 4'b0110, "R6"); rd(7, "R6"); wr(7, 4'b1001, "R6"); rd(7, "R6");
        wr(8, 4'h0, "R6"); rd(8, "R6"); rd(7, "R6"); idle("R6"); idle("R6");

        // R7/R8: linear write burst from 5; advances with bad enables and wr_n high
        cyc(1'b1, 1'b1, 3'b010, 1'b0, 4'h0, 5, 1'b1, "R7");
        adv(1'b1, 4'b1100, 1'b1, "R7");
        adv(1'b1, 4'h0, 1'b1, "R7");
        adv(1'b0, 4'b0011, 1'b1, "R7");
        idle("R7"); idle("R7");
        // R8: interleaved read burst from 6, order input flipped mid burst
        cyc(1'b1, 1'b1, 3'b010, 1'b1, 4'hF, 6, 1'b0, "R8");
        adv(1'b0, 4'h0, 1'b1, "R8"); adv(1'b0, 4'h0, 1'b1, "R8"); adv(1'b1, 4'h0, 1'b1, "R8");
        // R8: linear read burst from 30, six beats to show wrap
        cyc(1'b1, 1'b1, 3'b010, 1'b1, 4'hF, 30, 1'b1, "R8");
        for (int j = 0; j < 5; j++) adv(1'b0, 4'h0, 1'b0, "R8");
        // R8: interleaved write burst from 17 then read back
        cyc(1'b1, 1'b1, 3'b010, 1'b0, 4'h0, 17, 1'b0, "R8");
        adv(1'b0, 4'h0, 1'b0, "R8"); adv(1'b0, 4'h0, 1'b0, "R8"); adv(1'b0, 4'h0, 1'b0, "R8");
        for (int a = 16; a < 20; a++) rd(a, "R8");
        idle("R8"); idle("R8");

        // R2: each enable alone deselects; advance after deselect stays quiet
        rd(4, "R2"); cyc(1'b1, 1'b1, 3'b110, 1'b1, 4'hF, 4, 1'b1, "R2");
        rd(4, "R2"); cyc(1'b1, 1'b1, 3'b000, 1'b1, 4'hF, 4, 1'b1, "R2");
        rd(4, "R2"); cyc(1'b1, 1'b1, 3'b011, 1'b1, 4'hF, 4, 1'b1, "R2");
        cyc(1'b1, 1'b0, 3'b010, 1'b1, 4'hF, 4, 1'b1, "R7");
        cyc(1'b1, 1'b0, 3'b010, 1'b0, 4'h0, 4, 1'b1, "R7");
        idle("R2"); idle("R2");

        // R9: stalls with commands present, while driving, and mid-write
        rd(9, "R9");
        cyc(1'b0, 1'b1, 3'b010, 1'b0, 4'h0, 9, 1'b1, "R9");
        cyc(1'b0, 1'b1, 3'b010, 1'b1, 4'hF, 10, 1'b1, "R9");
        idle("R9");
        cyc(1'b0, 1'b1, 3'b010, 1'b1, 4'hF, 11, 1'b1, "R9");
        cyc(1'b0, 1'b0, 3'b010, 1'b0, 4'h0, 11, 1'b1, "R9");
        idle("R9");
        wr(10, 4'h0, "R9");
        cyc(1'b0, 1'b1, 3'b010, 1'b1, 4'hF, 0, 1'b1, "R9");
        idle("R9");
        cyc(1'b0, 1'b1, 3'b010, 1'b1, 4'hF, 0, 1'b1, "R9");
        cyc(1'b0, 1'b1, 3'b010, 1'b1, 4'hF, 0, 1'b1, "R9");
        rd(10, "R9"); idle("R9"); idle("R9");

        // R10: output enable acts without a clock edge
        rd(4, "R10"); idle("R10");
        direct(d_oe, 1'b1, "R10 driven");
        oe_n = 1'b1;
        #1 direct(d_oe, 1'b0, "R10 oe high");
        oe_n = 1'b0;
        #1 direct(d_oe, 1'b1, "R10 oe low again");
        idle("R10"); idle("R10");

        repeat (2) @(posedge clk);
        #6;
        report();
        $finish;
    end
endmodule